// File: doc/BRIEF.md
# Firmware Update Frame Builder

This block turns one firmware-upgrade command into a serial byte frame for a small master/slave link. A single start handshake supplies everything the frame needs: the command code, request or response direction, framing mode, the two node IDs and the numeric parameters (image size, segment length, segment number). The builder then puts the frame out one byte per accepted beat on a valid/ready stream and flags the final byte. Two check codes are computed while the frame is being sent. A short 8-bit code protects the four-byte header. A 16-bit code covers everything before it.

There are two framing modes. Point-to-point frames carry sender and receiver IDs and a sequence word. Bus frames leave these out and are five bytes shorter. For a segment-transmit request, the segment bytes are pulled from a second valid/ready input stream and placed into the frame as they arrive. No extra buffering is used.

Top module: `fwf_frame_builder`

## Requirements
- R1: After reset `out_valid` and `pl_ready` are 0 and `start_ready` is 1.
- R2: Byte 0 is 0x55. Bytes 1 and 2 carry a 16-bit word, low byte first. Bits 9:0 of the word hold the total frame length in bytes. Bits 15:10 hold the version code: 1 in point-to-point mode (`p2p_mode`=1) and 0 in bus mode.
- R3: Byte 3 is a CRC8 over bytes 0 to 2. It is computed MSB first with polynomial 0xFE and initial value 0xFE.
- R4: Point-to-point mode places sender ID at byte 4, receiver ID at byte 5, a zero sequence word at bytes 6 and 7, the type byte at 8 and the command code at 9; data begins at byte 10. Bus mode places the command code at byte 4 and data begins at byte 5.
- R5: In the type byte, bit 7 equals `is_resp` and bit 6 equals its inverse. Bits 5:0 are zero.
- R6: Data per command (codes 0 update, 1 image-info, 2 segment transmit, 3 finish):
  - Update request: nine bytes of 0x5E.
  - Image-info request: 0x00, `fw_size` in 4 bytes, then 8 zero bytes.
  - Image-info response: 0x00, then `seg_size` in 2 bytes.
  - Every other response, and a finish request: one 0x00 byte.
  - Multi-byte fields go least significant byte first.
- R7: A segment-transmit request carries 0x00, then `seg_seq` in 4 bytes and `seg_size` in 2 bytes, both LSB first. It then carries exactly `seg_size` bytes taken in order from the payload stream. `pl_ready` is asserted only while those bytes are due.
- R8: The last two bytes are a CRC16 over all earlier bytes, sent low byte first. It is computed MSB first with polynomial 0xFEFE and initial value 0xFEFE.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. `out_last` is high only on the final byte.
- R10: `start_ready` goes low when a start is accepted and stays low until the final byte is taken. Starts presented meanwhile are ignored and produce no further frame.
- R11: The number of bytes sent equals the length field: 10 header bytes (5 in bus mode) plus the data plus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Command present |
| start_ready | output | 1 | Builder idle, command accepted |
| p2p_mode | input | 1 | 1 point-to-point, 0 bus |
| is_resp | input | 1 | 1 response, 0 request |
| cmd_id | input | 2 | Command code |
| sender_id | input | 8 | Sender node ID |
| receiver_id | input | 8 | Receiver node ID |
| fw_size | input | 32 | Firmware image size |
| seg_size | input | 16 | Segment length in bytes |
| seg_seq | input | 32 | Segment sequence number |
| pl_valid | input | 1 | Segment byte available |
| pl_data | input | 8 | Segment byte |
| pl_ready | output | 1 | Segment byte taken |
| out_valid | output | 1 | Frame byte available |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of frame |
| out_ready | input | 1 | Downstream takes byte |

## Verification
The hardest case to create from the ports is a segment frame where both streams stall at the same time. In that case the output register drains while the payload input has no byte ready, so the running CRC16 must skip those cycles. The stimulus drops `out_ready` and `pl_valid` at random on independent draws over many segment frames of random length, including empty and several-hundred-byte segments. It also holds a conflicting start request during the first bytes of each frame to show that such a request is ignored.

// File: rtl/fwf_pkg.sv
package fwf_pkg;
  typedef enum logic [1:0] {
    CMD_UPDATE   = 2'd0,
    CMD_FW_INFO  = 2'd1,
    CMD_SEG_XFER = 2'd2,
    CMD_FINISH   = 2'd3
  } fwf_cmd_e;

  localparam logic [7:0]  SOF_BYTE   = 8'h55;
  localparam logic [7:0]  UPD_FILL   = 8'h5E;
  localparam logic [7:0]  HDR_KEY    = 8'hFE;
  localparam logic [15:0] PKT_KEY    = 16'hFEFE;
  localparam int          P2P_HDR    = 10;
  localparam int          BUS_HDR    = 5;
  localparam int          UPD_FILL_N = 9;
  localparam int          INFO_REQ_N = 13;
  localparam int          INFO_RSP_N = 3;
  localparam int          SEG_HDR_N  = 7;
  localparam int          CRC_BYTES  = 2;

  typedef struct packed {
    logic        p2p;
    logic        resp;
    fwf_cmd_e    cmd;
    logic [7:0]  snd;
    logic [7:0]  rcv;
    logic [31:0] fw_size;
    logic [15:0] seg_size;
    logic [31:0] seg_seq;
  } fwf_req_t;
endpackage

// File: rtl/fwf_crc_acc.sv
module fwf_crc_acc #(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = '1,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q;
  logic [W-1:0] stage [0:8];

  assign stage[0] = crc_q;

  // one MSB-first shift step per data bit, unrolled
  for (genvar g = 0; g < 8; g++) begin : g_bit
    logic fb;
    assign fb = stage[g][W-1] ^ din[7-g];
    assign stage[g+1] = {stage[g][W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= INIT;
    else if (en)    crc_q <= stage[8];
  end

  assign crc = crc_q;
endmodule

// File: rtl/fwf_frame_len.sv
module fwf_frame_len import fwf_pkg::*; #(
  parameter int LEN_W = 10
) (
  input  fwf_req_t         req,
  output logic [LEN_W-1:0] frame_len,
  output logic [LEN_W-1:0] hdr_len
);
  logic [LEN_W-1:0] pay_len;

  always_comb begin
    hdr_len = req.p2p ? LEN_W'(P2P_HDR) : LEN_W'(BUS_HDR);
    unique case (req.cmd)
      CMD_UPDATE:   pay_len = req.resp ? LEN_W'(1) : LEN_W'(UPD_FILL_N);
      CMD_FW_INFO:  pay_len = req.resp ? LEN_W'(INFO_RSP_N) : LEN_W'(INFO_REQ_N);
      CMD_SEG_XFER: pay_len = req.resp ? LEN_W'(1)
                                       : LEN_W'(SEG_HDR_N) + LEN_W'(req.seg_size);
      default:      pay_len = LEN_W'(1);
    endcase
    frame_len = hdr_len + pay_len + LEN_W'(CRC_BYTES);
  end
endmodule

// File: rtl/fwf_byte_sel.sv
module fwf_byte_sel import fwf_pkg::*; #(
  parameter int LEN_W = 10
) (
  input  fwf_req_t         req,
  input  logic [LEN_W-1:0] idx,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic [7:0]       crc8,
  input  logic [15:0]      crc16,
  input  logic [7:0]       stream_byte,
  output logic [7:0]       byte_o,
  output logic             from_stream
);
  localparam int VER_W = 16 - LEN_W;

  logic [15:0] vl_word;
  logic [7:0]  type_byte;
  int          ii, dd, fl, hl;

  assign vl_word   = {VER_W'(req.p2p), frame_len};
  assign type_byte = {req.resp, ~req.resp, 6'b0};

  always_comb begin
    ii = int'(idx);
    fl = int'(frame_len);
    hl = int'(hdr_len);
    dd = ii - hl;
    byte_o      = 8'h00;
    from_stream = 1'b0;
    if (ii == fl - 2) begin
      byte_o = crc16[7:0];
    end else if (ii == fl - 1) begin
      byte_o = crc16[15:8];
    end else if (ii < hl) begin
      case (ii)
        0:       byte_o = SOF_BYTE;
        1:       byte_o = vl_word[7:0];
        2:       byte_o = vl_word[15:8];
        3:       byte_o = crc8;
        4:       byte_o = req.p2p ? req.snd : {6'b0, req.cmd};
        5:       byte_o = req.rcv;
        8:       byte_o = type_byte;
        9:       byte_o = {6'b0, req.cmd};
        default: byte_o = 8'h00;
      endcase
    end else begin
      unique case (req.cmd)
        CMD_UPDATE: byte_o = req.resp ? 8'h00 : UPD_FILL;
        CMD_FW_INFO: begin
          if (!req.resp) begin
            if (dd >= 1 && dd <= 4) byte_o = 8'(req.fw_size >> (8 * (dd - 1)));
          end else begin
            if (dd == 1)      byte_o = req.seg_size[7:0];
            else if (dd == 2) byte_o = req.seg_size[15:8];
          end
        end
        CMD_SEG_XFER: begin
          if (!req.resp) begin
            if (dd >= 1 && dd <= 4) byte_o = 8'(req.seg_seq >> (8 * (dd - 1)));
            else if (dd == 5)       byte_o = req.seg_size[7:0];
            else if (dd == 6)       byte_o = req.seg_size[15:8];
            else if (dd >= SEG_HDR_N) begin
              byte_o      = stream_byte;
              from_stream = 1'b1;
            end
          end
        end
        default: byte_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/fwf_frame_builder.sv
module fwf_frame_builder import fwf_pkg::*; #(
  parameter int LEN_W = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_valid,
  output logic        start_ready,
  input  logic        p2p_mode,
  input  logic        is_resp,
  input  logic [1:0]  cmd_id,
  input  logic [7:0]  sender_id,
  input  logic [7:0]  receiver_id,
  input  logic [31:0] fw_size,
  input  logic [15:0] seg_size,
  input  logic [31:0] seg_seq,
  input  logic        pl_valid,
  input  logic [7:0]  pl_data,
  output logic        pl_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready
);
  fwf_req_t         req_in, req_q;
  logic             busy_q, loaded_q;
  logic [LEN_W-1:0] idx_q, frame_len, hdr_len;
  logic             out_valid_q, out_last_q;
  logic [7:0]       out_data_q, next_byte;
  logic             from_stream, room, accept, adv, is_final;
  logic [7:0]       crc8;
  logic [15:0]      crc16;

  always_comb begin
    req_in          = '0;
    req_in.p2p      = p2p_mode;
    req_in.resp     = is_resp;
    req_in.cmd      = fwf_cmd_e'(cmd_id);
    req_in.snd      = sender_id;
    req_in.rcv      = receiver_id;
    req_in.fw_size  = fw_size;
    req_in.seg_size = seg_size;
    req_in.seg_seq  = seg_seq;
  end

  fwf_frame_len #(.LEN_W(LEN_W)) u_len (
    .req(req_q), .frame_len(frame_len), .hdr_len(hdr_len)
  );

  fwf_byte_sel #(.LEN_W(LEN_W)) u_sel (
    .req(req_q), .idx(idx_q), .frame_len(frame_len), .hdr_len(hdr_len),
    .crc8(crc8), .crc16(crc16), .stream_byte(pl_data),
    .byte_o(next_byte), .from_stream(from_stream)
  );

  assign start_ready = !busy_q;
  assign accept      = start_valid && !busy_q;
  assign room        = !out_valid_q || out_ready;
  assign adv         = busy_q && !loaded_q && room && (!from_stream || pl_valid);
  assign pl_ready    = busy_q && !loaded_q && room && from_stream;
  assign is_final    = (idx_q == frame_len - LEN_W'(1));

  fwf_crc_acc #(.W(8), .POLY(HDR_KEY), .INIT(HDR_KEY)) u_crc8 (
    .clk(clk), .rst(rst), .clr(accept),
    .en(adv && (idx_q < LEN_W'(3))), .din(next_byte), .crc(crc8)
  );

  fwf_crc_acc #(.W(16), .POLY(PKT_KEY), .INIT(PKT_KEY)) u_crc16 (
    .clk(clk), .rst(rst), .clr(accept),
    .en(adv && (idx_q < frame_len - LEN_W'(CRC_BYTES))), .din(next_byte), .crc(crc16)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      loaded_q    <= 1'b0;
      idx_q       <= '0;
      req_q       <= '0;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (accept) begin
        busy_q   <= 1'b1;
        loaded_q <= 1'b0;
        idx_q    <= '0;
        req_q    <= req_in;
      end
      if (adv) begin
        out_data_q  <= next_byte;
        out_valid_q <= 1'b1;
        out_last_q  <= is_final;
        idx_q       <= idx_q + LEN_W'(1);
        if (is_final) loaded_q <= 1'b1;
      end else if (out_valid_q && out_ready) begin
        out_valid_q <= 1'b0;
        out_last_q  <= 1'b0;
        if (out_last_q) busy_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_last  = out_last_q;

  // beat counter kept for the checks below only
  logic [LEN_W-1:0] beat_q;
  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else if (out_valid_q && out_ready) beat_q <= out_last_q ? '0 : beat_q + LEN_W'(1);
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_sof_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && beat_q == '0) |-> (out_data == SOF_BYTE));

  assert_frame_len_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |-> (beat_q == frame_len - LEN_W'(1)));

  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (start_valid && start_ready) |=> !start_ready);

  assert_no_pull_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> !pl_ready);
endmodule

// File: tb/test_fwf_frame_builder.sv
`timescale 1ns/1ps
module test_fwf_frame_builder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic        p2p_mode = 1'b0, is_resp = 1'b0;
  logic [1:0]  cmd_id = '0;
  logic [7:0]  sender_id = '0, receiver_id = '0;
  logic [31:0] fw_size = '0, seg_seq = '0;
  logic [15:0] seg_size = '0;
  logic        pl_valid = 1'b0;
  logic [7:0]  pl_data = '0;
  logic        pl_ready;
  logic        out_valid, out_last;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_b [0:1100];
  logic [7:0] rec_b [0:1100];
  logic [7:0] seg_b [0:1023];
  int exp_len, exp_hdr;

  always #2 clk = ~clk;

  fwf_frame_builder i_fwf_frame_builder (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
    .p2p_mode(p2p_mode), .is_resp(is_resp), .cmd_id(cmd_id),
    .sender_id(sender_id), .receiver_id(receiver_id), .fw_size(fw_size),
    .seg_size(seg_size), .seg_seq(seg_seq), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_ready(pl_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] m_crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'hFE) : (r << 1);
    return r;
  endfunction

  function automatic logic [15:0] m_crc16(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'hFEFE) : (r << 1);
    return r;
  endfunction

  function automatic string tag_of(input int i, input bit p2p, input bit segreq);
    if (i < 3) return "R2";
    if (i == 3) return "R3";
    if (i >= exp_len - 2) return "R8";
    if (p2p && i == 8) return "R5";
    if (i < exp_hdr) return "R4";
    if (segreq) return "R7";
    return "R6";
  endfunction

  task automatic build_exp(input bit p2p, input bit resp, input int cmd, input logic [7:0] snd,
                           input logic [7:0] rcv, input logic [31:0] fsz, input int ssz,
                           input logic [31:0] seq);
    int p;
    logic [7:0] c8;
    logic [15:0] c16;
    exp_hdr = p2p ? 10 : 5;
    p = exp_hdr;
    if (cmd == 0 && !resp) begin
      for (int k = 0; k < 9; k++) begin exp_b[p] = 8'h5E; p++; end
    end else if (cmd == 1 && !resp) begin
      exp_b[p] = 0; p++;
      for (int k = 0; k < 4; k++) begin exp_b[p] = fsz[8*k +: 8]; p++; end
      for (int k = 0; k < 8; k++) begin exp_b[p] = 0; p++; end
    end else if (cmd == 1) begin
      exp_b[p] = 0; exp_b[p+1] = ssz[7:0]; exp_b[p+2] = ssz[15:8]; p += 3;
    end else if (cmd == 2 && !resp) begin
      exp_b[p] = 0; p++;
      for (int k = 0; k < 4; k++) begin exp_b[p] = seq[8*k +: 8]; p++; end
      exp_b[p] = ssz[7:0]; exp_b[p+1] = ssz[15:8]; p += 2;
      for (int k = 0; k < ssz; k++) begin exp_b[p] = seg_b[k]; p++; end
    end else begin
      exp_b[p] = 0; p++;
    end
    exp_len = p + 2;
    exp_b[0] = 8'h55;
    exp_b[1] = exp_len[7:0];
    exp_b[2] = {5'b0, p2p, exp_len[9:8]};
    c8 = 8'hFE;
    for (int k = 0; k < 3; k++) c8 = m_crc8(c8, exp_b[k]);
    exp_b[3] = c8;
    if (p2p) begin
      exp_b[4] = snd; exp_b[5] = rcv; exp_b[6] = 0; exp_b[7] = 0;
      exp_b[8] = {resp, ~resp, 6'b0}; exp_b[9] = 8'(cmd);
    end else begin
      exp_b[4] = 8'(cmd);
    end
    c16 = 16'hFEFE;
    for (int k = 0; k < exp_len - 2; k++) c16 = m_crc16(c16, exp_b[k]);
    exp_b[exp_len-2] = c16[7:0];
    exp_b[exp_len-1] = c16[15:8];
  endtask

  task automatic run_frame(input bit p2p, input bit resp, input int cmd, input int ssz,
                           input bit stall);
    logic [7:0] snd = 8'($urandom), rcv = 8'($urandom);
    logic [31:0] fsz = $urandom, seq = $urandom;
    int n = 0, ptr = 0;
    bit done = 0, prev_hold = 0;
    logic [7:0] prev_data = 0;
    bit segreq = (cmd == 2 && !resp);
    int nseg = segreq ? ssz : 0;
    for (int k = 0; k < ssz; k++) seg_b[k] = 8'($urandom);
    build_exp(p2p, resp, cmd, snd, rcv, fsz, ssz, seq);
    @(negedge clk);
    chk(start_ready == 1'b1, "R10 idle ready", int'(start_ready), 1);
    p2p_mode = p2p; is_resp = resp; cmd_id = 2'(cmd); sender_id = snd; receiver_id = rcv;
    fw_size = fsz; seg_size = 16'(ssz); seg_seq = seq; start_valid = 1'b1;
    @(negedge clk);
    // conflicting start held while busy: must be ignored
    p2p_mode = ~p2p; cmd_id = 2'(cmd + 1); sender_id = ~snd; seg_size = 16'(ssz + 3);
    chk(start_ready == 1'b0, "R10 busy", int'(start_ready), 0);
    while (!done) begin
      if (n >= 3) start_valid = 1'b0;
      out_ready = stall ? ($urandom % 4 != 0) : 1'b1;
      pl_valid  = (ptr < nseg) && (stall ? ($urandom % 3 != 0) : 1'b1);
      pl_data   = seg_b[ptr];
      #1;
      if (prev_hold) chk(out_valid && out_data == prev_data, "R9 hold", int'(out_data), int'(prev_data));
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (out_valid && out_ready) begin
        rec_b[n] = out_data;
        chk(out_last == (n == exp_len - 1), "R9 last flag", int'(out_last), int'(n == exp_len - 1));
        n++;
        if (out_last || n > 1090) done = 1;
      end
      if (pl_valid && pl_ready) ptr++;
      @(negedge clk);
    end
    start_valid = 1'b0; pl_valid = 1'b0;
    chk(n == exp_len, "R11 byte count", n, exp_len);
    chk(ptr == nseg, "R7 stream bytes", ptr, nseg);
    for (int i = 0; i < n && i < exp_len; i++)
      chk(rec_b[i] === exp_b[i], tag_of(i, p2p, segreq && i >= exp_hdr + 7), int'(rec_b[i]), int'(exp_b[i]));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 no extra frame", int'(out_valid), 0);
    chk(start_ready == 1'b1, "R10 ready after", int'(start_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(pl_ready == 1'b0, "R1 pl_ready", int'(pl_ready), 0);
    chk(start_ready == 1'b1, "R1 start_ready", int'(start_ready), 1);
    @(negedge clk);
    rst = 1'b0;
    // directed: every command and direction in both modes
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 2; r++)
          run_frame(m[0], r[0], c, 5, 1'b0);
    // segment corners: empty, single byte, long
    run_frame(1'b1, 1'b0, 2, 0, 1'b1);
    run_frame(1'b0, 1'b0, 2, 1, 1'b1);
    run_frame(1'b1, 1'b0, 2, 300, 1'b1);
    run_frame(1'b0, 1'b0, 2, 300, 1'b0);
    // random mix with stalls on both streams
    for (int k = 0; k < 60; k++)
      run_frame(1'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 65), 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule